// File: doc/BRIEF.md
# Four-Source Configurable Interrupt Controller

This block turns four asynchronous signals into one host interrupt request. Each signal is the lowest data line of the first port in one of four I/O banks. Each bank has its own configuration register. That register holds an enable bit and a two-bit trigger selection: active-low level, active-high level, high-to-low transition or low-to-high transition. Every source passes through a two-flop synchronizer before the trigger logic sees it. Edge triggers compare the synchronized value with the value one cycle older.

A detected condition on an enabled bank sets that bank's pending flag. The host reads all four flags through one shared status register. The read returns the flags and clears them in the same cycle. If a trigger fires in the cycle of the read, the flag survives. A level trigger whose level is still present therefore shows up again at once. The request line to the host is a registered OR of the four flags.

Register access uses a simple synchronous strobe interface. Read data is registered and appears on the clock edge that follows the read strobe. The trigger encoding is a state-like enumeration decoded with a unique case per source. The named variants are TRIG_LOW, TRIG_HIGH, TRIG_FALL and TRIG_RISE, and the transitions between them happen only by register writes.

Top module: `quad_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0x00, so all banks are disabled. The status register reads 0x00 and `irq_o` is 0.
- R2: The configuration registers of banks 1 to 4 are at byte offsets 0x04, 0x0C, 0x14 and 0x1C. Bit 2 is the enable (1 = enabled) and bits 1:0 are the trigger code. A write stores only bits 2:0, and bits 7:3 always read 0.
- R3: Trigger code 00 sets the bank's pending flag on every cycle in which the synchronized source is 0.
- R4: Trigger code 01 sets the pending flag on every cycle in which the synchronized source is 1.
- R5: Trigger code 10 sets the pending flag when the synchronized source was 1 one cycle earlier and is 0 now.
- R6: Trigger code 11 sets the pending flag when the synchronized source was 0 one cycle earlier and is 1 now.
- R7: While a bank's enable bit is 0, its trigger condition never sets its pending flag.
- R8: The status register is at offset 0x05. Bits 0 to 3 hold the pending flags of banks 1 to 4 (1 = pending) and bits 7:4 read 0. For any read, `bus_rdata` takes the addressed value on the clock edge where `bus_rd` is sampled high, and holds it otherwise.
- R9: A status read clears all pending flags, except a flag whose trigger condition is true in the read cycle. A still-active level is therefore pending again right after the read, and an edge is not.
- R10: A source change driven between clock edges sets its pending flag on the third rising edge that follows it.
- R11: `irq_o` equals the OR of the four pending flags delayed by one clock.
- R12: Writes to the status offset change nothing, and reads of any offset that holds no register return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 4 | Asynchronous interrupt sources, bit n from bank n+1 |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume that the status register is narrower than the data bus. The stimulus issues at most one register operation per cycle, and it changes the sources only just after a falling clock edge. This lets the two-flop synchronizer see clean values. Random traffic mixes status reads, configuration reads and writes with random data, and reads of unused offsets. Source bits flip with low probability, so levels persist across reads and edges are sparse enough to tell apart.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic       en;
        trig_mode_e mode;
    } bank_cfg_t;

    localparam int CFG_BITS = $bits(bank_cfg_t);

endpackage

// File: rtl/irqc_src_detect.sv
module irqc_src_detect
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       async_in,
    input  trig_mode_e mode,
    output logic       event_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
        end
    end

    assign level = chain_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    always_comb begin
        unique case (mode)
            TRIG_LOW:  event_o = ~level;
            TRIG_HIGH: event_o = level;
            TRIG_FALL: event_o = prev_q & ~level;
            TRIG_RISE: event_o = ~prev_q & level;
            default:   event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int              NSRC       = 4,
    parameter int              AW         = 5,
    parameter logic [AW-1:0]   CFG_BASE   = 5'h04,
    parameter int              CFG_STRIDE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [CFG_BITS-1:0]      wdata,
    output bank_cfg_t [NSRC-1:0]     cfg_o,
    output logic      [NSRC-1:0]     hit_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bank
        localparam logic [AW-1:0] MY_ADDR = AW'(int'(CFG_BASE) + i * CFG_STRIDE);

        assign hit_o[i] = (addr == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[i] <= '{en: 1'b0, mode: TRIG_LOW};
            end else if (wr_en && hit_o[i]) begin
                cfg_o[i] <= bank_cfg_t'(wdata);
            end
        end
    end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic            irq_o
);

    logic [NSRC-1:0] pend_nxt;

    always_comb begin
        pend_nxt = clr_i ? '0 : pend_o;
        pend_nxt = pend_nxt | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= '0;
        end else begin
            pend_o <= pend_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |pend_o;
        end
    end

endmodule

// File: rtl/quad_irq_ctrl.sv
module quad_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int            NSRC        = 4,
    parameter int            AW          = 5,
    parameter int            DW          = 8,
    parameter logic [AW-1:0] CFG_BASE    = 5'h04,
    parameter int            CFG_STRIDE  = 8,
    parameter logic [AW-1:0] STAT_ADDR   = 5'h05,
    parameter int            SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o
);

    localparam int PAD_CFG  = DW - CFG_BITS;
    localparam int PAD_STAT = DW - NSRC;

    bank_cfg_t [NSRC-1:0] cfg;
    logic      [NSRC-1:0] cfg_hit;
    logic      [NSRC-1:0] evt_v;
    logic      [NSRC-1:0] en_v;
    logic      [NSRC-1:0] set_v;
    logic      [NSRC-1:0] pend_q;
    logic                 stat_rd;
    logic      [DW-1:0]   rd_val;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:CFG_BITS];

    irqc_cfg_regs #(
        .NSRC       (NSRC),
        .AW         (AW),
        .CFG_BASE   (CFG_BASE),
        .CFG_STRIDE (CFG_STRIDE)
    ) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata[CFG_BITS-1:0]),
        .cfg_o (cfg),
        .hit_o (cfg_hit)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irqc_src_detect #(
            .SYNC_STAGES (SYNC_STAGES)
        ) i_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (src_i[i]),
            .mode     (cfg[i].mode),
            .event_o  (evt_v[i])
        );
        assign en_v[i] = cfg[i].en;
    end

    assign set_v   = evt_v & en_v;
    assign stat_rd = bus_rd && (bus_addr == STAT_ADDR);

    irqc_pending #(
        .NSRC (NSRC)
    ) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (stat_rd),
        .pend_o (pend_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_val = '0;
        if (bus_addr == STAT_ADDR) begin
            rd_val = {{PAD_STAT{1'b0}}, pend_q};
        end
        for (int i = 0; i < NSRC; i++) begin
            if (cfg_hit[i]) begin
                rd_val = {{PAD_CFG{1'b0}}, cfg[i]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

endmodule

// File: rtl/quad_irq_ctrl_chk.sv
module quad_irq_ctrl_chk #(
    parameter int NSRC = 4,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stat_rd,
    input logic [NSRC-1:0] set_v,
    input logic [NSRC-1:0] en_v,
    input logic [NSRC-1:0] pend_q,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq_o
);

    // R11: request line is the flag OR one clock late
    a_r11_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|pend_q));

    // R9: a status read leaves only flags whose trigger fired in that cycle
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((pend_q & ~$past(set_v)) == '0));

    // R8: unused status bits come back as zero
    a_r8_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (bus_rdata[DW-1:NSRC] == '0));

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // R7: a disabled, clear flag stays clear
        a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[i] && !pend_q[i]) |=> !pend_q[i]);

        // R9: a trigger wins over a simultaneous clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> pend_q[i]);
    end

endmodule

bind quad_irq_ctrl quad_irq_ctrl_chk #(
    .NSRC (NSRC),
    .DW   (DW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .set_v     (set_v),
    .en_v      (en_v),
    .pend_q    (pend_q),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
);

// File: tb/test_quad_irq_ctrl.sv
module test_quad_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src = 4'hF;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int ntot = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    quad_irq_ctrl i_quad_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    // expected-value model built from the requirements
    logic [3:0] m_s1, m_s2, m_prev, m_pend;
    logic       m_irq;
    logic [7:0] m_rdata;
    logic [2:0] m_cfg [4];

    function automatic logic [3:0] exp_set();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            case (m_cfg[i][1:0])
                2'b00:   r[i] = !m_s2[i];
                2'b01:   r[i] = m_s2[i];
                2'b10:   r[i] = m_prev[i] && !m_s2[i];
                default: r[i] = !m_prev[i] && m_s2[i];
            endcase
            r[i] = r[i] && m_cfg[i][2];
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        logic [7:0] v = 8'h00;
        if (a == 5'h05) v = {4'h0, m_pend};
        for (int i = 0; i < 4; i++)
            if (a == 5'(4 + 8 * i)) v = {5'b0, m_cfg[i]};
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
            m_irq <= 1'b0; m_rdata <= '0;
            for (int i = 0; i < 4; i++) m_cfg[i] <= '0;
        end else begin
            m_pend <= ((bus_rd && bus_addr == 5'h05) ? 4'h0 : m_pend) | exp_set();
            m_irq  <= |m_pend;
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= src;
            if (bus_rd) m_rdata <= exp_read(bus_addr);
            if (bus_wr)
                for (int i = 0; i < 4; i++)
                    if (bus_addr == 5'(4 + 8 * i)) m_cfg[i] <= bus_wdata[2:0];
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        ntot++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) check({7'b0, irq}, {7'b0, m_irq}, "R11 irq");
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        check(bus_rdata, exp, tag);
        check(bus_rdata, m_rdata, {tag, " model"});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({7'b0, irq}, 8'h00, "R1 irq after reset");
        idle(4);
        for (int i = 0; i < 4; i++) rd(5'(4 + 8 * i), 8'h00, "R1 cfg reset");
        rd(5'h05, 8'h00, "R1 status reset");

        // R2 field layout
        wr(5'h0C, 8'hFA); rd(5'h0C, 8'h02, "R2 masked write");
        wr(5'h1C, 8'hFF); rd(5'h1C, 8'h07, "R2 all bits");
        wr(5'h1C, 8'h00); wr(5'h0C, 8'h00);
        idle(3); rd(5'h05, 8'h00, "R2 clear");

        // R3 low level, bank 1
        wr(5'h04, 8'h04); idle(3);
        rd(5'h05, 8'h00, "R3 high input no flag");
        src[0] = 1'b0; idle(3);
        rd(5'h05, 8'h01, "R3 low level");
        rd(5'h05, 8'h01, "R9 level sets again");
        src[0] = 1'b1; idle(3);
        rd(5'h05, 8'h01, "R9 last level read");
        rd(5'h05, 8'h00, "R9 cleared");
        wr(5'h04, 8'h00);

        // R4 high level, bank 2
        wr(5'h0C, 8'h05); idle(2);
        rd(5'h05, 8'h02, "R4 high level");
        src[1] = 1'b0; idle(3);
        rd(5'h05, 8'h02, "R4 drain");
        rd(5'h05, 8'h00, "R4 cleared");
        wr(5'h0C, 8'h00);

        // R5 falling edge, bank 3
        wr(5'h14, 8'h06); idle(2);
        rd(5'h05, 8'h00, "R5 steady high");
        src[2] = 1'b0; idle(3);
        rd(5'h05, 8'h04, "R5 falling edge");
        rd(5'h05, 8'h00, "R9 edge not re-set");
        wr(5'h14, 8'h00);

        // R6 rising edge, bank 4, with R10 latency
        wr(5'h1C, 8'h07);
        src[3] = 1'b0; idle(3);
        rd(5'h05, 8'h00, "R6 falling ignored");
        src[3] = 1'b1;
        tick(); check({7'b0, irq}, 8'h00, "R10 edge 1");
        tick(); check({7'b0, irq}, 8'h00, "R10 edge 2");
        tick(); check({7'b0, irq}, 8'h00, "R10 edge 3");
        tick(); check({7'b0, irq}, 8'h01, "R10 R11 edge 4");
        rd(5'h05, 8'h08, "R6 rising edge");
        check({7'b0, irq}, 8'h01, "R11 still high");
        tick(); check({7'b0, irq}, 8'h00, "R11 dropped");
        // R9 edge in the read cycle survives
        src[3] = 1'b0; idle(3); rd(5'h05, 8'h00, "R9 prep");
        src[3] = 1'b1; tick(); tick();
        rd(5'h05, 8'h00, "R9 coincident read");
        rd(5'h05, 8'h08, "R9 flag survived");
        wr(5'h1C, 8'h00);

        // R7 disabled bank
        wr(5'h0C, 8'h01);
        src[1] = 1'b1; idle(4);
        rd(5'h05, 8'h00, "R7 disabled");
        check({7'b0, irq}, 8'h00, "R7 irq low");
        wr(5'h0C, 8'h00);

        // R12 status writes and unused offsets
        wr(5'h05, 8'hFF);
        rd(5'h05, 8'h00, "R12 status write ignored");
        rd(5'h06, 8'h00, "R12 unused offset");
        rd(5'h00, 8'h00, "R12 offset zero");
        rd(5'h1F, 8'h00, "R12 top offset");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [4:0] a;
            for (int b = 0; b < 4; b++)
                if ($urandom_range(0, 7) == 0) src[b] = ~src[b];
            r = $urandom_range(0, 39);
            if (r < 7) begin
                rd(5'h05, exp_read(5'h05), "R8 R9 random status");
            end else if (r < 10) begin
                a = 5'(4 + 8 * $urandom_range(0, 3));
                rd(a, exp_read(a), "R2 random cfg read");
            end else if (r < 12) begin
                a = 5'(4 + 8 * $urandom_range(0, 3));
                wr(a, 8'($urandom));
            end else if (r < 13) begin
                a = 5'($urandom);
                rd(a, exp_read(a), "R12 random offset");
            end else begin
                tick();
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            ntot++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", ntot - nfail, ntot);
            $finish;
        end
    end

endmodule